// File: doc/BRIEF.md
# Message-Signalled Interrupt Termination Bank

This block is the landing zone for message-signalled interrupts. A device signals an interrupt by writing a small value to a chosen address; the address picks one of 16 groups and one of 8 pending registers inside that group, and the low four bits of the data pick one of 16 bits in that register, which the block then sets. Each pending register is therefore a 16-bit set of outstanding vectors, and the bank as a whole tracks 2048 vectors.

Software services a group from its summary register, which has one bit per pending register of the group. It reads each flagged pending register, which hands back the outstanding bits and clears them in the same access. Every group drives its own level interrupt output, which stays high for as long as anything in that group is outstanding. Message writes arrive on their own port, so a message and a servicing read can land in the same cycle; the freshly posted bit is never lost.

Top module: `msi_term_bank`

## Requirements
- R1: After reset every pending bit is clear, every interrupt output is low, `rd_valid` is low, and every register reads as zero.
- R2: A message write with `msg_valid` high to byte offset (g << 19) + (x << 16), g in 0..15 and x in 0..7, sets bit `msg_data[3:0]` of pending register x of group g at the next clock edge; bits 31:4 of `msg_data` are ignored and no other register changes.
- R3: A register-port read of pending register x of group g (same offset as R2) returns its 16 pending bits in `rd_data[15:0]`, with bits 31:16 zero, and `rd_valid` high, one cycle after the request, and leaves that register clear.
- R4: A read of the summary register of group g, at offset 0x800000 + (g << 16), returns in bit x a 1 exactly when pending register x of that group is non-zero; bits 31:8 are zero.
- R5: `irq[g]` is high from the clock edge that posts the first pending bit of group g until the edge of the read that clears the group's last non-zero pending register.
- R6: When a message write and a clearing read address the same pending register in the same cycle, the read returns the value held before that edge and the newly written bit remains pending afterwards.
- R7: Register-port writes (`reg_we` high) change no state at any offset, including the summary registers, and produce no `rd_valid`.
- R8: A read of any offset that is neither a pending register nor a summary register (low 16 bits non-zero, or offset 0x900000 and above) returns zero with `rd_valid` high; a message write to such an offset changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Inbound message write strobe |
| msg_addr | input | 24 | Byte offset of the message write |
| msg_data | input | 32 | Message data; bits 3:0 select the vector bit |
| reg_req | input | 1 | Register-port access strobe |
| reg_we | input | 1 | Register-port access is a write |
| reg_addr | input | 24 | Register-port byte offset |
| reg_wdata | input | 32 | Register-port write data (has no effect) |
| rd_valid | output | 1 | Read data is valid this cycle |
| rd_data | output | 32 | Read data |
| irq | output | 16 | Level interrupt, one per group |

## Verification
Every result of this bank is due one clock edge after its stimulus: a message write shows in the pending register, the summary bit and the interrupt output right after the edge that samples it, and a read returns its data with `rd_valid` on the edge that samples the request, the same edge that clears the register. The bench drives all inputs on the falling edge and samples on the next falling edge, half a period after the edge that makes the result, so each check looks at exactly the cycle its requirement names. The same-cycle collision is driven by one task that raises both strobes on the same falling edge and then reads the register a second time to see the surviving bit.

// File: rtl/msi_term_pkg.sv
package msi_term_pkg;

  // default geometry of the bank
  localparam int NUM_GROUPS  = 16;
  localparam int IDX_PER_GRP = 8;
  localparam int VEC_PER_IDX = 16;
  localparam int WIN_SHIFT   = 16;  // each register owns a 64 KiB window
  localparam int DATA_W      = 32;

  // what an offset decodes to
  typedef enum logic [1:0] {
    REGION_NONE    = 2'd0,
    REGION_INDEX   = 2'd1,
    REGION_SUMMARY = 2'd2
  } region_e;

endpackage

// File: rtl/msi_term_decode.sv
module msi_term_decode
  import msi_term_pkg::*;
#(
  parameter int NG        = NUM_GROUPS,
  parameter int NI        = IDX_PER_GRP,
  parameter int WSH       = WIN_SHIFT,
  parameter int GW        = $clog2(NG),
  parameter int IW        = $clog2(NI),
  parameter int ADDR_W    = WSH + IW + GW + 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output region_e           region_o,
  output logic [GW-1:0]     grp_o,
  output logic [IW-1:0]     idx_o
);

  localparam int GRP_SHIFT = WSH + IW;      // group field of a pending offset
  localparam int SUM_BIT   = GRP_SHIFT + GW; // top bit: summary space

  // offset classification, kept in one function so a reader can compare it
  // against the address rules line by line
  function automatic region_e classify(input logic [ADDR_W-1:0] a);
    if (a[WSH-1:0] != '0)               return REGION_NONE;
    if (!a[SUM_BIT])                    return REGION_INDEX;
    if (a[SUM_BIT-1:WSH+GW] != '0)      return REGION_NONE;
    return REGION_SUMMARY;
  endfunction

  function automatic logic [GW-1:0] group_of(input logic [ADDR_W-1:0] a);
    if (a[SUM_BIT]) return a[WSH +: GW];
    return a[GRP_SHIFT +: GW];
  endfunction

  function automatic logic [IW-1:0] index_of(input logic [ADDR_W-1:0] a);
    return a[WSH +: IW];
  endfunction

  assign region_o = classify(addr_i);
  assign grp_o    = group_of(addr_i);
  assign idx_o    = index_of(addr_i);

endmodule

// File: rtl/msi_term_group.sv
module msi_term_group #(
  parameter int NI = 8,
  parameter int NV = 16,
  parameter int IW = $clog2(NI),
  parameter int VW = $clog2(NV)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [IW-1:0]    set_idx,
  input  logic [VW-1:0]    set_bit,
  input  logic             clr_en,
  input  logic [IW-1:0]    clr_idx,
  output logic [NI*NV-1:0] pend_o,
  output logic [NI-1:0]    summary_o,
  output logic             irq_o
);

  logic [NV-1:0] pend_q [NI];

  function automatic logic [NV-1:0] bit_mask(input logic [VW-1:0] b);
    return NV'(1) << b;
  endfunction

  // events the assertions watch
  wire set_clr_collide = set_en && clr_en && (set_idx == clr_idx);
  wire clr_alone       = clr_en && !set_clr_collide;

  for (genvar i = 0; i < NI; i++) begin : g_idx
    wire           set_here = set_en && (set_idx == IW'(i));
    wire           clr_here = clr_en && (clr_idx == IW'(i));
    wire [NV-1:0]  add_bits = set_here ? bit_mask(set_bit) : '0;

    always_ff @(posedge clk) begin
      if (!rst_n) pend_q[i] <= '0;
      else        pend_q[i] <= (clr_here ? '0 : pend_q[i]) | add_bits;
    end

    assign pend_o[i*NV +: NV] = pend_q[i];
    assign summary_o[i]       = |pend_q[i];
  end

  assign irq_o = |summary_o;

  // R2
  set_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> pend_q[$past(set_idx)][$past(set_bit)]);

  // R3
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_alone |=> (pend_q[$past(clr_idx)] == '0));

  // R6
  collide_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_clr_collide |=> (pend_q[$past(clr_idx)] == bit_mask($past(set_bit))));

  // R5
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(set_en));

  // R5
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o) |-> $past(clr_en));

endmodule

// File: rtl/msi_term_readback.sv
module msi_term_readback
  import msi_term_pkg::*;
#(
  parameter int NG     = 16,
  parameter int NI     = 8,
  parameter int NV     = 16,
  parameter int DW     = 32,
  parameter int GW     = $clog2(NG),
  parameter int IW     = $clog2(NI)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_en,
  input  region_e             region,
  input  logic [GW-1:0]       grp,
  input  logic [IW-1:0]       idx,
  input  logic [NG*NI*NV-1:0] pend_all,
  input  logic [NG*NI-1:0]    summary_all,
  output logic                rd_valid_o,
  output logic [DW-1:0]       rd_data_o
);

  logic [DW-1:0] sel_word;

  always_comb begin
    sel_word = '0;
    unique case (region)
      REGION_INDEX:   sel_word = DW'(pend_all[(int'(grp) * NI + int'(idx)) * NV +: NV]);
      REGION_SUMMARY: sel_word = DW'(summary_all[int'(grp) * NI +: NI]);
      default:        sel_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_en;
      rd_data_o  <= rd_en ? sel_word : '0;
    end
  end

endmodule

// File: rtl/msi_term_bank.sv
module msi_term_bank
  import msi_term_pkg::*;
#(
  parameter int NG     = NUM_GROUPS,
  parameter int NI     = IDX_PER_GRP,
  parameter int NV     = VEC_PER_IDX,
  parameter int WSH    = WIN_SHIFT,
  parameter int DW     = DATA_W,
  parameter int GW     = $clog2(NG),
  parameter int IW     = $clog2(NI),
  parameter int VW     = $clog2(NV),
  parameter int ADDR_W = WSH + IW + GW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msg_valid,
  input  logic [ADDR_W-1:0] msg_addr,
  input  logic [DW-1:0]     msg_data,
  input  logic              reg_req,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic              rd_valid,
  output logic [DW-1:0]     rd_data,
  output logic [NG-1:0]     irq
);

  region_e         msg_region, reg_region;
  logic [GW-1:0]   msg_grp, reg_grp;
  logic [IW-1:0]   msg_idx, reg_idx;

  logic [NG*NI*NV-1:0] pend_all;
  logic [NG*NI-1:0]    summary_all;

  // register-port writes are accepted and dropped
  wire unused_wdata = ^{reg_wdata, msg_data[DW-1:VW]};

  msi_term_decode #(.NG(NG), .NI(NI), .WSH(WSH), .GW(GW), .IW(IW), .ADDR_W(ADDR_W))
    u_msg_dec (.addr_i(msg_addr), .region_o(msg_region), .grp_o(msg_grp), .idx_o(msg_idx));

  msi_term_decode #(.NG(NG), .NI(NI), .WSH(WSH), .GW(GW), .IW(IW), .ADDR_W(ADDR_W))
    u_reg_dec (.addr_i(reg_addr), .region_o(reg_region), .grp_o(reg_grp), .idx_o(reg_idx));

  // named events
  wire msg_post    = msg_valid && (msg_region == REGION_INDEX);
  wire rd_req      = reg_req && !reg_we;
  wire rd_clearing = rd_req && (reg_region == REGION_INDEX);
  wire rd_unmapped = rd_req && (reg_region == REGION_NONE);

  for (genvar g = 0; g < NG; g++) begin : g_grp
    wire set_g = msg_post    && (msg_grp == GW'(g));
    wire clr_g = rd_clearing && (reg_grp == GW'(g));

    msi_term_group #(.NI(NI), .NV(NV), .IW(IW), .VW(VW)) u_group (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_en    (set_g),
      .set_idx   (msg_idx),
      .set_bit   (msg_data[VW-1:0]),
      .clr_en    (clr_g),
      .clr_idx   (reg_idx),
      .pend_o    (pend_all[g*NI*NV +: NI*NV]),
      .summary_o (summary_all[g*NI +: NI]),
      .irq_o     (irq[g])
    );
  end

  msi_term_readback #(.NG(NG), .NI(NI), .NV(NV), .DW(DW), .GW(GW), .IW(IW)) u_rdback (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_en       (rd_req),
    .region      (reg_region),
    .grp         (reg_grp),
    .idx         (reg_idx),
    .pend_all    (pend_all),
    .summary_all (summary_all),
    .rd_valid_o  (rd_valid),
    .rd_data_o   (rd_data)
  );

  // R8
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_unmapped |=> (rd_valid && (rd_data == '0)));

  // R7
  write_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_we) |=> !rd_valid);

  // R7
  write_keeps_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_we && !msg_valid) |=> $stable(irq));

  // R3
  read_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clearing |=> (rd_valid && (rd_data[DW-1:NV] == '0)));

endmodule

// File: tb/msi_term_bank_tb.sv
`timescale 1ns/1ps
module msi_term_bank_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        msg_valid;
  logic [23:0] msg_addr;
  logic [31:0] msg_data;
  logic        reg_req;
  logic        reg_we;
  logic [23:0] reg_addr;
  logic [31:0] reg_wdata;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic [15:0] irq;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;  // 125 MHz

  msi_term_bank u_dut (
    .clk(clk), .rst_n(rst_n),
    .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_data(msg_data),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .irq(irq)
  );

  // offsets restated from the requirements
  function automatic logic [23:0] pend_off(input int g, input int x);
    return 24'(g * 32'h80000 + x * 32'h10000);
  endfunction
  function automatic logic [23:0] sum_off(input int g);
    return 24'(32'h800000 + g * 32'h10000);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    msg_valid = 0; reg_req = 0; reg_we = 0;
  endtask

  task automatic do_msg(input logic [23:0] a, input logic [31:0] d);
    @(negedge clk); msg_valid = 1; msg_addr = a; msg_data = d;
    @(negedge clk); idle();
  endtask

  task automatic do_write(input logic [23:0] a, input logic [31:0] d);
    @(negedge clk); reg_req = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); idle();
  endtask

  task automatic do_read(input logic [23:0] a, output logic v, output logic [31:0] d);
    @(negedge clk); reg_req = 1; reg_we = 0; reg_addr = a;
    @(negedge clk); v = rd_valid; d = rd_data; idle();
  endtask

  task automatic do_both(input logic [23:0] a, input logic [31:0] md,
                         output logic v, output logic [31:0] d);
    @(negedge clk);
    msg_valid = 1; msg_addr = a; msg_data = md;
    reg_req = 1; reg_we = 0; reg_addr = a;
    @(negedge clk); v = rd_valid; d = rd_data; idle();
  endtask

  // op: 0 message write, 1 read, 2 register write
  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  req;
    logic [23:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t TBL [NVEC] = '{
    '{2'd0, 8'd2, 24'h1D0000, 32'h0000_0007, 32'h0},     // R2 g3 x5 bit7
    '{2'd0, 8'd2, 24'h1D0000, 32'hABCD_0012, 32'h0},     // R2 upper data ignored, bit2
    '{2'd1, 8'd4, 24'h830000, 32'h0, 32'h0000_0020},     // R4 summary g3
    '{2'd1, 8'd3, 24'h1D0000, 32'h0, 32'h0000_0084},     // R3 read returns bits
    '{2'd1, 8'd3, 24'h1D0000, 32'h0, 32'h0000_0000},     // R3 cleared by read
    '{2'd0, 8'd2, 24'h000000, 32'h0000_000F, 32'h0},     // R2 g0 x0 bit15
    '{2'd0, 8'd2, 24'h7F0000, 32'h0000_0000, 32'h0},     // R2 g15 x7 bit0
    '{2'd1, 8'd4, 24'h8F0000, 32'h0, 32'h0000_0080},     // R4 summary g15
    '{2'd1, 8'd4, 24'h800000, 32'h0, 32'h0000_0001},     // R4 summary g0
    '{2'd1, 8'd3, 24'h000000, 32'h0, 32'h0000_8000},     // R3
    '{2'd1, 8'd3, 24'h7F0000, 32'h0, 32'h0000_0001},     // R3
    '{2'd0, 8'd8, 24'h1D0004, 32'h0000_0003, 32'h0},     // R8 misaligned message dropped
    '{2'd1, 8'd8, 24'h1D0000, 32'h0, 32'h0000_0000},     // R8 nothing landed
    '{2'd1, 8'd8, 24'h900000, 32'h0, 32'h0000_0000},     // R8 unmapped read
    '{2'd2, 8'd7, 24'h830000, 32'h0000_00FF, 32'h0},     // R7 summary write ignored
    '{2'd1, 8'd7, 24'h830000, 32'h0, 32'h0000_0000}      // R7 summary still zero
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    logic        v;
    logic [31:0] d;
    idle(); msg_addr = 0; msg_data = 0; reg_addr = 0; reg_wdata = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    check("R1 irq", 32'(irq), 32'h0);
    check("R1 rd_valid", 32'(rd_valid), 32'h0);
    do_read(pend_off(6, 2), v, d);
    check("R1 pending reads zero", d, 32'h0);
    do_read(sum_off(6), v, d);
    check("R1 summary reads zero", d, 32'h0);

    // vector table
    for (int k = 0; k < NVEC; k++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", TBL[k].req, k);
      case (TBL[k].op)
        2'd0: do_msg(TBL[k].addr, TBL[k].data);
        2'd2: begin
          do_write(TBL[k].addr, TBL[k].data);
          check({tag, " no rd_valid"}, 32'(rd_valid), 32'h0);
        end
        default: begin
          do_read(TBL[k].addr, v, d);
          check({tag, " valid"}, 32'(v), 32'h1);
          check(tag, d, TBL[k].exp);
        end
      endcase
    end

    // R5 interrupt follows pending state of group 9
    check("R5 irq idle", 32'(irq), 32'h0);
    do_msg(pend_off(9, 1), 32'd5);
    check("R5 irq raised", 32'(irq), 32'h0200);
    do_msg(pend_off(9, 6), 32'd11);
    do_read(pend_off(9, 1), v, d);
    check("R5 data x1", d, 32'h0020);
    check("R5 irq held while x6 pending", 32'(irq), 32'h0200);
    do_read(pend_off(9, 6), v, d);
    check("R5 data x6", d, 32'h0800);
    check("R5 irq dropped", 32'(irq), 32'h0);

    // R6 collision of message and clearing read
    do_msg(pend_off(2, 3), 32'd4);
    do_both(pend_off(2, 3), 32'd9, v, d);
    check("R6 read returns old value", d, 32'h0010);
    check("R6 irq stays high", 32'(irq), 32'h0004);
    do_read(pend_off(2, 3), v, d);
    check("R6 new bit survived", d, 32'h0200);
    check("R6 irq clear afterwards", 32'(irq), 32'h0);

    // R7 register-port write to a pending register has no effect
    do_write(pend_off(4, 0), 32'h1);
    check("R7 irq unchanged", 32'(irq), 32'h0);
    do_read(pend_off(4, 0), v, d);
    check("R7 pending untouched", d, 32'h0);

    // R8 message beyond the summary space is dropped
    do_msg(24'hA00000, 32'd1);
    check("R8 irq unchanged", 32'(irq), 32'h0);

    // R2 isolation: neighbour register not disturbed
    do_msg(pend_off(12, 4), 32'd3);
    do_read(pend_off(12, 5), v, d);
    check("R2 neighbour untouched", d, 32'h0);
    do_read(pend_off(12, 4), v, d);
    check("R2 target bit", d, 32'h0008);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule